// File: doc/BRIEF.md
# Serial Frame Synchronizer and Deframer

This block sits behind a clock recovery stage and receives a serial bit stream, one bit on every clock. The stream is cut into fixed 80-bit frames. Each frame opens with an 8-bit start marker, which is followed by a data-present flag, a 68-bit payload word, an odd-parity bit and a two-bit stop field. The block first hunts for the marker. It then confirms that the marker recurs at exactly the frame period over several frames, and only then declares lock. Once locked, it never searches again: a bit-position counter that wraps at the frame length predicts every later frame boundary.

For each frame seen while locked, the block checks parity and the stop field. It delivers the payload with a one-cycle strobe when both checks pass and the frame is flagged as carrying data. A failed check produces a one-cycle error pulse and no data, and it leaves lock in place. Lock is given up only when the marker is absent at the predicted boundary for several frames in a row. A synchronous active-high reset returns the block to the hunt state.

Top module: `fsync_deframer`

## Requirements
- R1: While reset is high, and on the first cycle after it, `sync_locked`, `frame_valid` and `frame_err` are all 0.
- R2: `sync_locked` rises on the cycle after the last bit of the third marker, provided the three markers (value 8'hD4, first bit sent = bit 7) started exactly 80 bits apart. Before that point it stays 0, and no frame output is produced.
- R3: A marker whose spacing from the previous one is not exactly 80 bits breaks the confirmation run. The run then restarts at that marker, so three further evenly spaced markers are needed, counted from that one.
- R4: The frame layout, in transmission order, is: marker (8 bits), flag (1 bit, 1 = data present), payload (68 bits, MSB first), parity (1 bit), stop (2 bits, both 1). When a locked frame passes its checks and its flag is 1, `frame_data` holds the payload and `frame_valid` is high for one cycle, on the cycle after the last stop bit.
- R5: A locked frame whose flag is 0 and whose checks pass produces neither `frame_valid` nor `frame_err`.
- R6: The flag, the payload and the parity bit together must hold an odd number of ones. A locked frame that breaks this rule raises `frame_err` for one cycle, in the cycle where a strobe would have come, and gives no `frame_valid`. Lock is kept.
- R7: A locked frame whose stop field is not 2'b11 raises `frame_err` for one cycle and gives no `frame_valid`. Lock is kept.
- R8: While locked, a marker that is missing at a predicted boundary does not disturb the timing. The frame is still deframed at the predicted position. A correct marker clears the run of misses.
- R9: Lock drops on the cycle after the fourth marker in a row that is missing at a predicted boundary, and the frame that follows this fourth missing marker yields no output.
- R10: While locked, `frame_valid` pulses last one cycle and are at least 80 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Recovered serial data bit |
| frame_data | output | 68 | Payload of the last accepted frame |
| frame_valid | output | 1 | One-cycle strobe for an accepted frame |
| frame_err | output | 1 | One-cycle pulse on a parity or stop-field failure |
| sync_locked | output | 1 | Frame boundary is locked |

## Verification
If the bit-position counter or the confirmation count were wrong, `sync_locked` would rise one frame early or late. It could also rise after markers at uneven spacing, and this becomes visible within about 240 bits of the first marker. A misplaced frame boundary shows on the first locked frame: the payload is shifted, and parity or stop errors replace strobes. A wrong miss count shows as lock surviving, or being lost, one frame away from the fourth missing marker. The bench therefore samples every strobe, error pulse and lock edge at the exact bit after which it is due.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCK    = 2'd2
    } sync_state_e;
endpackage

// File: rtl/fsync_shift.sv
// Shift window over the most recent bits plus marker comparison on the newest byte.
module fsync_shift #(
    parameter int          WIN_W  = 72,
    parameter int          MARK_W = 8,
    parameter logic [7:0]  MARKER = 8'hD4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_bit,
    output logic [WIN_W-1:0] window,
    output logic             mark_hit
);
    logic [WIN_W-2:0] hist_d, hist_q;

    always_comb begin
        window   = {hist_q, ser_bit};
        hist_d   = window[WIN_W-2:0];
        mark_hit = (window[MARK_W-1:0] == MARKER[MARK_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_d;
    end
endmodule

// File: rtl/fsync_check.sv
// Splits a frame body into fields and evaluates parity and stop checks.
module fsync_check #(
    parameter int WIN_W  = 72,
    parameter int PAY_W  = 68,
    parameter int STOP_W = 2
) (
    input  logic [WIN_W-1:0] window,
    output logic [PAY_W-1:0] payload,
    output logic             flag,
    output logic             checks_ok
);
    logic [STOP_W-1:0] stop_f;
    logic              odd_ok;

    always_comb begin
        stop_f    = window[STOP_W-1:0];
        payload   = window[STOP_W+PAY_W:STOP_W+1];
        flag      = window[WIN_W-1];
        odd_ok    = ^window[WIN_W-1:STOP_W];
        checks_ok = odd_ok && (&stop_f);
    end
endmodule

// File: rtl/fsync_deframer.sv
module fsync_deframer
    import fsync_pkg::*;
#(
    parameter int         FRAME_LEN  = 80,
    parameter int         MARK_W     = 8,
    parameter int         STOP_W     = 2,
    parameter logic [7:0] MARKER     = 8'hD4,
    parameter int         LOCK_HITS  = 3,
    parameter int         MISS_LIMIT = 4,
    localparam int        BODY_W     = FRAME_LEN - MARK_W,
    localparam int        PAY_W      = BODY_W - STOP_W - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_bit,
    output logic [PAY_W-1:0] frame_data,
    output logic             frame_valid,
    output logic             frame_err,
    output logic             sync_locked
);
    localparam int PH_W   = $clog2(FRAME_LEN);
    localparam int CMAX   = (LOCK_HITS > MISS_LIMIT) ? LOCK_HITS : MISS_LIMIT;
    localparam int CNT_W  = $clog2(CMAX + 1);
    localparam logic [PH_W-1:0]  PH_BODY_END = PH_W'(BODY_W - 1);
    localparam logic [PH_W-1:0]  PH_MARK_END = PH_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] HITS_N      = CNT_W'(LOCK_HITS);
    localparam logic [CNT_W-1:0] MISS_N      = CNT_W'(MISS_LIMIT);

    typedef struct packed {
        sync_state_e      st;
        logic [PH_W-1:0]  phase;
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] misses;
        logic [PAY_W-1:0] data;
        logic             valid;
        logic             err;
    } ctl_t;

    ctl_t             c_d, c_q;
    logic [BODY_W-1:0] window;
    logic              mark_hit;
    logic [PAY_W-1:0]  payload;
    logic              flag;
    logic              checks_ok;

    fsync_shift #(.WIN_W(BODY_W), .MARK_W(MARK_W), .MARKER(MARKER)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ser_bit  (ser_bit),
        .window   (window),
        .mark_hit (mark_hit)
    );

    fsync_check #(.WIN_W(BODY_W), .PAY_W(PAY_W), .STOP_W(STOP_W)) u_check (
        .window    (window),
        .payload   (payload),
        .flag      (flag),
        .checks_ok (checks_ok)
    );

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        c_d.err   = 1'b0;
        c_d.phase = (c_q.phase == PH_MARK_END) ? '0 : c_q.phase + 1'b1;
        unique case (c_q.st)
            ST_HUNT: begin
                c_d.phase = '0;
                if (mark_hit) begin
                    c_d.st   = ST_CONFIRM;
                    c_d.hits = CNT_W'(1);
                end
            end
            ST_CONFIRM: begin
                if (c_q.phase == PH_MARK_END) begin
                    if (mark_hit) begin
                        c_d.hits = c_q.hits + 1'b1;
                        if (c_q.hits + 1'b1 >= HITS_N) begin
                            c_d.st     = ST_LOCK;
                            c_d.misses = '0;
                        end
                    end else begin
                        c_d.st = ST_HUNT;
                    end
                end
            end
            ST_LOCK: begin
                if (c_q.phase == PH_BODY_END) begin
                    if (!checks_ok) begin
                        c_d.err = 1'b1;
                    end else if (flag) begin
                        c_d.valid = 1'b1;
                        c_d.data  = payload;
                    end
                end
                if (c_q.phase == PH_MARK_END) begin
                    if (mark_hit) begin
                        c_d.misses = '0;
                    end else if (c_q.misses + 1'b1 >= MISS_N) begin
                        c_d.st     = ST_HUNT;
                        c_d.misses = '0;
                    end else begin
                        c_d.misses = c_q.misses + 1'b1;
                    end
                end
            end
            default: c_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q        <= '0;
            c_q.st     <= ST_HUNT;
        end else begin
            c_q <= c_d;
        end
    end

    assign frame_data  = c_q.data;
    assign frame_valid = c_q.valid;
    assign frame_err   = c_q.err;
    assign sync_locked = (c_q.st == ST_LOCK);
endmodule

// File: rtl/fsync_checker.sv
module fsync_checker #(
    parameter int FRAME_LEN = 80
) (
    input logic clk,
    input logic rst,
    input logic frame_valid,
    input logic frame_err,
    input logic sync_locked
);
    localparam int GW = $clog2(FRAME_LEN + 1);
    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst || !sync_locked) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (frame_valid) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GW'(FRAME_LEN)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!sync_locked && !frame_valid && !frame_err));

    a_r4_valid_needs_lock: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> sync_locked);

    a_r6_err_excludes_valid: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !frame_valid);

    a_r7_err_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    a_r10_valid_spacing: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && seen_q) |-> (gap_q >= GW'(FRAME_LEN - 1)));

    a_r2_no_data_at_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_locked) |-> !frame_valid);
endmodule

bind fsync_deframer fsync_checker #(.FRAME_LEN(FRAME_LEN)) u_fsync_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_valid (frame_valid),
    .frame_err   (frame_err),
    .sync_locked (sync_locked)
);

// File: tb/fsync_deframer_test.sv
module fsync_deframer_test;
    localparam logic [7:0] MK = 8'hD4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_bit = 1'b0;
    logic [67:0] frame_data;
    logic        frame_valid, frame_err, sync_locked;

    int tests_run = 0;
    int tests_failed = 0;
    int n_valid = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    fsync_deframer uut (
        .clk         (clk),
        .rst         (rst),
        .ser_bit     (ser_bit),
        .frame_data  (frame_data),
        .frame_valid (frame_valid),
        .frame_err   (frame_err),
        .sync_locked (sync_locked)
    );

    always @(posedge clk) begin
        #2;
        if (!rst && frame_valid) n_valid++;
        if (!rst && frame_err)   n_err++;
    end

    task automatic chk(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [79:0] mk_frame(input logic [7:0] m, input logic fl,
                                             input logic [67:0] pay, input bit par_bad,
                                             input logic [1:0] stop);
        logic par;
        par = ~(^{fl, pay});
        if (par_bad) par = ~par;
        return {m, fl, pay, par, stop};
    endfunction

    // Drive one bit now (at a falling edge) and wait for the next falling edge.
    task automatic send_bit(input logic b);
        ser_bit = b;
        @(negedge clk);
    endtask

    task automatic send_range(input logic [79:0] f, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) send_bit(f[i]);
    endtask

    task automatic send_frame(input logic [79:0] f);
        send_range(f, 79, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ser_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (5) send_bit(1'b0);
        n_valid = 0;
        n_err = 0;
    endtask

    task automatic lock_up();
        do_reset();
        repeat (3) send_frame(mk_frame(MK, 1'b1, 68'h1_1111_2222_3333_4444, 0, 2'b11));
        n_valid = 0;
        n_err = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!sync_locked && !frame_valid && !frame_err, "R1 outputs in reset",
            {sync_locked, frame_valid, frame_err}, 0);
        rst = 1'b0;
        send_bit(1'b0);
        chk(!sync_locked && !frame_valid && !frame_err, "R1 outputs after reset",
            {sync_locked, frame_valid, frame_err}, 0);
    endtask

    task automatic t_lock();
        logic [79:0] fc;
        do_reset();
        send_frame(mk_frame(MK, 1'b1, 68'hA_0000_0000_0000_0001, 0, 2'b11));
        send_frame(mk_frame(MK, 1'b1, 68'hB_0000_0000_0000_0002, 0, 2'b11));
        chk(!sync_locked, "R2 unlocked after two markers", sync_locked, 0);
        chk(n_valid == 0, "R2 no data before lock", n_valid, 0);
        fc = mk_frame(MK, 1'b1, 68'hA_5A5A_1234_5678_9ABC, 0, 2'b11);
        send_range(fc, 79, 73);
        chk(!sync_locked, "R2 unlocked one bit before third marker ends", sync_locked, 0);
        send_range(fc, 72, 72);
        chk(sync_locked, "R2 locked after third marker", sync_locked, 1);
        send_range(fc, 71, 0);
        chk(frame_valid == 1'b1, "R4 strobe after last stop bit", frame_valid, 1);
        chk(frame_data == 68'hA_5A5A_1234_5678_9ABC, "R4 payload", frame_data, 68'hA_5A5A_1234_5678_9ABC);
        send_bit(1'b1);
        chk(frame_valid == 1'b0, "R10 strobe lasts one cycle", frame_valid, 0);
    endtask

    task automatic t_spacing();
        do_reset();
        send_frame(mk_frame(MK, 1'b1, 68'h0_0F0F_0F0F_0F0F_0F0F, 0, 2'b11));
        send_bit(1'b0);
        send_frame(mk_frame(MK, 1'b1, 68'h0_0F0F_0F0F_0F0F_0F0F, 0, 2'b11));
        send_frame(mk_frame(MK, 1'b1, 68'h0_0F0F_0F0F_0F0F_0F0F, 0, 2'b11));
        chk(!sync_locked, "R3 slipped marker restarts confirmation", sync_locked, 0);
        send_frame(mk_frame(MK, 1'b1, 68'h3_3333_0000_CCCC_5555, 0, 2'b11));
        chk(sync_locked, "R3 locks after three evenly spaced markers", sync_locked, 1);
        chk(frame_valid && frame_data == 68'h3_3333_0000_CCCC_5555, "R3 first locked frame output",
            frame_data, 68'h3_3333_0000_CCCC_5555);
    endtask

    task automatic t_flag();
        lock_up();
        send_frame(mk_frame(MK, 1'b0, 68'h7_7777_7777_7777_7777, 0, 2'b11));
        chk(!frame_valid && !frame_err, "R5 empty frame no strobe", {frame_valid, frame_err}, 0);
        chk(n_valid == 0 && n_err == 0, "R5 empty frame counts", n_valid + n_err, 0);
    endtask

    task automatic t_parity();
        lock_up();
        send_frame(mk_frame(MK, 1'b1, 68'h5_0000_FFFF_0000_1234, 1, 2'b11));
        chk(frame_err && !frame_valid, "R6 parity error pulse", {frame_err, frame_valid}, 2'b10);
        chk(sync_locked, "R6 lock kept", sync_locked, 1);
        send_frame(mk_frame(MK, 1'b1, 68'h6_1234_0000_0000_0006, 0, 2'b11));
        chk(frame_valid && frame_data == 68'h6_1234_0000_0000_0006, "R6 next frame accepted",
            frame_data, 68'h6_1234_0000_0000_0006);
        chk(n_err == 1 && n_valid == 1, "R6 counts", {n_err[7:0], n_valid[7:0]}, 16'h0101);
    endtask

    task automatic t_stop();
        lock_up();
        send_frame(mk_frame(MK, 1'b1, 68'h9_8765_4321_0FED_CBA9, 0, 2'b10));
        chk(frame_err && !frame_valid, "R7 stop error pulse", {frame_err, frame_valid}, 2'b10);
        send_frame(mk_frame(MK, 1'b1, 68'h9_8765_4321_0FED_CBA9, 0, 2'b01));
        chk(frame_err && !frame_valid, "R7 second stop error", {frame_err, frame_valid}, 2'b10);
        chk(sync_locked && n_valid == 0, "R7 lock kept without data", {sync_locked, n_valid[7:0]}, 9'h100);
    endtask

    task automatic t_miss();
        lock_up();
        repeat (3) send_frame(mk_frame(8'h00, 1'b1, 68'hC_0000_0000_0000_00C0, 0, 2'b11));
        chk(sync_locked, "R8 lock held over three missing markers", sync_locked, 1);
        chk(n_valid == 3, "R8 frames still deframed", n_valid, 3);
        send_frame(mk_frame(MK, 1'b1, 68'hD_0000_0000_0000_00D0, 0, 2'b11));
        n_valid = 0;
        repeat (3) send_frame(mk_frame(8'h00, 1'b1, 68'hE_0000_0000_0000_00E0, 0, 2'b11));
        chk(sync_locked, "R8 good marker cleared miss run", sync_locked, 1);
        send_range(mk_frame(8'h00, 1'b1, 68'hF_0000_0000_0000_00F0, 0, 2'b11), 79, 72);
        chk(!sync_locked, "R9 lock dropped at fourth missing marker", sync_locked, 0);
        send_range(mk_frame(8'h00, 1'b1, 68'hF_0000_0000_0000_00F0, 0, 2'b11), 71, 0);
        chk(n_valid == 3 && !frame_valid, "R9 no output after drop", n_valid, 3);
    endtask

    task automatic t_stream();
        lock_up();
        for (int k = 0; k < 4; k++)
            send_frame(mk_frame(MK, 1'b1, {k[3:0], 64'h0123_4567_89AB_CDEF}, 0, 2'b11));
        chk(n_valid == 4, "R10 one strobe per frame", n_valid, 4);
        chk(frame_data == {4'd3, 64'h0123_4567_89AB_CDEF}, "R4 last payload in stream",
            frame_data, {4'd3, 64'h0123_4567_89AB_CDEF});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_lock();
        t_spacing();
        t_flag();
        t_parity();
        t_stop();
        t_miss();
        t_stream();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule